// File: doc/BRIEF.md
# Reservation Station Bank with Tag Wakeup

This block holds instructions that have been dispatched but cannot yet execute because one or both operands are still being produced. It has five stations. Each station serves one function unit: integer ALU, load, store, floating-point unit A and floating-point unit B. A station stores the operation code, a destination tag, two source tags and two source values. The destination tag is the reorder-buffer entry number of the instruction. Because the unit writes back by that number, a station can be released in the same cycle its instruction starts executing.

Dispatch targets a single station, selected by a unit code. If that station is occupied, dispatch is refused with a stall. Each cycle the completion bus broadcasts one tag and value. Every waiting source compares its tag against the bus tag and takes the value when they match. A station whose two sources are both ready raises its issue line to its unit for one cycle and is free again on the next cycle. A flush input empties the whole bank.

Top module: `rs_bank`

## Requirements
- R1: After reset, every `iss_valid` bit is 0 and `disp_stall` is 0 for any dispatch to a valid unit code.
- R2: An accepted dispatch with unit code u stores op, destination tag and both sources in station u. The codes are 0=ALU, 1=load, 2=store, 3=FP unit A, 4=FP unit B. If both sources are ready, `iss_valid[u]` is 1 in the cycle after the dispatch edge. The issue fields of lane u (bits u*W upward in each flat bus) then carry exactly the dispatched op, tag and values.
- R3: If `disp_valid` is 1 and station u is occupied, `disp_stall` is 1 in that same cycle. The refused dispatch leaves the station contents unchanged.
- R4: A source tag of 0 means the value is present. Any nonzero source tag means the value is outstanding. A station never issues while either of its source tags is nonzero.
- R5: A waiting source whose tag equals `cdb_tag` while `cdb_valid` is 1 captures `cdb_value` and is ready from the next cycle. A different tag, or `cdb_valid` at 0, has no effect.
- R6: If a source tag at dispatch equals the tag broadcast in the same cycle, the source takes the broadcast value at dispatch.
- R7: An issuing station raises `iss_valid` for exactly one cycle. It accepts a new dispatch without stall in the following cycle.
- R8: `flush` empties every station at the next edge and takes priority over a dispatch in the same cycle. Later broadcasts of the old tags do not bring any entry back.
- R9: Unit codes 5 to 7 cause `disp_stall` whenever `disp_valid` is 1, and nothing is allocated.
- R10: One broadcast wakes every matching source in every station in the same cycle, including both sources of a station whose two tags are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all stations |
| disp_valid | input | 1 | Dispatch request |
| disp_unit | input | 3 | Target unit code |
| disp_op | input | OP_W | Operation code |
| disp_tag | input | TAG_W | Destination reorder-buffer entry |
| disp_t1 | input | TAG_W | Source 1 tag, 0 = present |
| disp_t2 | input | TAG_W | Source 2 tag, 0 = present |
| disp_v1 | input | DATA_W | Source 1 value |
| disp_v2 | input | DATA_W | Source 2 value |
| disp_stall | output | 1 | Dispatch refused this cycle |
| cdb_valid | input | 1 | Completion broadcast valid |
| cdb_tag | input | TAG_W | Completion tag |
| cdb_value | input | DATA_W | Completion value |
| iss_valid | output | 5 | Per-unit issue strobe |
| iss_op | output | 5*OP_W | Per-unit op code |
| iss_tag | output | 5*TAG_W | Per-unit destination tag |
| iss_v1 | output | 5*DATA_W | Per-unit source 1 value |
| iss_v2 | output | 5*DATA_W | Per-unit source 2 value |

## Verification
`disp_stall` is combinational, so the bench samples it after driving inputs and before the clock edge. Dispatch, capture and flush all take effect at one edge. Their effects on the issue outputs are due in the cycle right after that edge, and the bench samples there, two nanoseconds past the edge. An issue is visible for one cycle and gone after the next edge, which the bench confirms sample by sample. The tag sweeps keep a small per-source pending model in the bench. This model predicts the cycle in which a station becomes ready.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int NUM_ST = 5;
  localparam int UNIT_W = 3;

  typedef enum logic [UNIT_W-1:0] {
    U_ALU   = 3'd0,
    U_LOAD  = 3'd1,
    U_STORE = 3'd2,
    U_FPA   = 3'd3,
    U_FPB   = 3'd4
  } unit_e;
endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int N  = 5,
  parameter int UW = 3
) (
  input  logic          disp_valid,
  input  logic [UW-1:0] disp_unit,
  input  logic [N-1:0]  busy_vec,
  output logic [N-1:0]  alloc_vec,
  output logic          stall
);
  logic [N-1:0] sel;
  logic         unit_ok;
  logic         target_busy;

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign sel[i] = (disp_unit == UW'(i));
  end

  assign unit_ok     = |sel;
  assign target_busy = |(sel & busy_vec);
  assign stall       = disp_valid && (!unit_ok || target_busy);
  assign alloc_vec   = (disp_valid && !stall) ? sel : '0;
endmodule

// File: rtl/rs_station.sv
module rs_station #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8,
  parameter int OP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc,
  input  logic [OP_W-1:0]   d_op,
  input  logic [TAG_W-1:0]  d_tag,
  input  logic [TAG_W-1:0]  d_t1,
  input  logic [TAG_W-1:0]  d_t2,
  input  logic [DATA_W-1:0] d_v1,
  input  logic [DATA_W-1:0] d_v2,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic              busy_o,
  output logic              issue_o,
  output logic [OP_W-1:0]   op_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [TAG_W-1:0]  t1_o,
  output logic [TAG_W-1:0]  t2_o,
  output logic [DATA_W-1:0] v1_o,
  output logic [DATA_W-1:0] v2_o
);
  // A pending source (nonzero tag) matches a valid broadcast of the same tag.
  function automatic logic snoop(input logic [TAG_W-1:0] src,
                                 input logic             bv,
                                 input logic [TAG_W-1:0] btag);
    return bv && (src != '0) && (src == btag);
  endfunction

  logic              busy_q;
  logic [OP_W-1:0]   op_q;
  logic [TAG_W-1:0]  tag_q, t1_q, t2_q;
  logic [DATA_W-1:0] v1_q, v2_q;

  logic new_hit1, new_hit2, held_hit1, held_hit2, ready;

  assign new_hit1  = snoop(d_t1, cdb_valid, cdb_tag);
  assign new_hit2  = snoop(d_t2, cdb_valid, cdb_tag);
  assign held_hit1 = snoop(t1_q, cdb_valid, cdb_tag);
  assign held_hit2 = snoop(t2_q, cdb_valid, cdb_tag);
  assign ready     = busy_q && (t1_q == '0) && (t2_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      tag_q  <= '0;
      t1_q   <= '0;
      t2_q   <= '0;
      v1_q   <= '0;
      v2_q   <= '0;
    end else if (flush) begin
      busy_q <= 1'b0;
    end else if (alloc) begin
      busy_q <= 1'b1;
      op_q   <= d_op;
      tag_q  <= d_tag;
      t1_q   <= new_hit1 ? '0 : d_t1;
      t2_q   <= new_hit2 ? '0 : d_t2;
      v1_q   <= new_hit1 ? cdb_value : d_v1;
      v2_q   <= new_hit2 ? cdb_value : d_v2;
    end else if (ready) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (held_hit1) begin
        t1_q <= '0;
        v1_q <= cdb_value;
      end
      if (held_hit2) begin
        t2_q <= '0;
        v2_q <= cdb_value;
      end
    end
  end

  assign busy_o  = busy_q;
  assign issue_o = ready;
  assign op_o    = op_q;
  assign tag_o   = tag_q;
  assign t1_o    = t1_q;
  assign t2_o    = t2_q;
  assign v1_o    = v1_q;
  assign v2_o    = v2_q;
endmodule

// File: rtl/rs_bank.sv
module rs_bank #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 8,
  parameter int OP_W   = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic                             disp_valid,
  input  logic [rs_pkg::UNIT_W-1:0]        disp_unit,
  input  logic [OP_W-1:0]                  disp_op,
  input  logic [TAG_W-1:0]                 disp_tag,
  input  logic [TAG_W-1:0]                 disp_t1,
  input  logic [TAG_W-1:0]                 disp_t2,
  input  logic [DATA_W-1:0]                disp_v1,
  input  logic [DATA_W-1:0]                disp_v2,
  output logic                             disp_stall,
  input  logic                             cdb_valid,
  input  logic [TAG_W-1:0]                 cdb_tag,
  input  logic [DATA_W-1:0]                cdb_value,
  output logic [rs_pkg::NUM_ST-1:0]        iss_valid,
  output logic [rs_pkg::NUM_ST*OP_W-1:0]   iss_op,
  output logic [rs_pkg::NUM_ST*TAG_W-1:0]  iss_tag,
  output logic [rs_pkg::NUM_ST*DATA_W-1:0] iss_v1,
  output logic [rs_pkg::NUM_ST*DATA_W-1:0] iss_v2
);
  localparam int N = rs_pkg::NUM_ST;

  logic [N-1:0]       busy_vec;
  logic [N-1:0]       alloc_vec;
  logic [N*TAG_W-1:0] t1_flat, t2_flat;

  rs_alloc #(.N(N), .UW(rs_pkg::UNIT_W)) u_alloc (
    .disp_valid (disp_valid),
    .disp_unit  (disp_unit),
    .busy_vec   (busy_vec),
    .alloc_vec  (alloc_vec),
    .stall      (disp_stall)
  );

  for (genvar i = 0; i < N; i++) begin : g_st
    rs_station #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_st (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .alloc     (alloc_vec[i]),
      .d_op      (disp_op),
      .d_tag     (disp_tag),
      .d_t1      (disp_t1),
      .d_t2      (disp_t2),
      .d_v1      (disp_v1),
      .d_v2      (disp_v2),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_value (cdb_value),
      .busy_o    (busy_vec[i]),
      .issue_o   (iss_valid[i]),
      .op_o      (iss_op[i*OP_W +: OP_W]),
      .tag_o     (iss_tag[i*TAG_W +: TAG_W]),
      .t1_o      (t1_flat[i*TAG_W +: TAG_W]),
      .t2_o      (t2_flat[i*TAG_W +: TAG_W]),
      .v1_o      (iss_v1[i*DATA_W +: DATA_W]),
      .v2_o      (iss_v2[i*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk #(
  parameter int N     = 5,
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             disp_stall,
  input logic             cdb_valid,
  input logic [TAG_W-1:0] cdb_tag,
  input logic [N-1:0]     iss_valid,
  input logic [N-1:0]     busy_vec,
  input logic [N-1:0]     alloc_vec,
  input logic [N*TAG_W-1:0] t1_flat,
  input logic [N*TAG_W-1:0] t2_flat
);
  // R2
  alloc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vec != '0 && !flush) |=> ((busy_vec & $past(alloc_vec)) == $past(alloc_vec)));

  // R3
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_stall |-> (alloc_vec == '0));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_vec == '0));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R4
    issue_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[i] |-> (busy_vec[i] && t1_flat[i*TAG_W +: TAG_W] == '0
                        && t2_flat[i*TAG_W +: TAG_W] == '0));

    // R7
    issue_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[i] |=> !iss_valid[i]);

    // R5
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_vec[i] && !flush && t1_flat[i*TAG_W +: TAG_W] != '0 &&
       !(cdb_valid && cdb_tag == t1_flat[i*TAG_W +: TAG_W]))
      |=> $stable(t1_flat[i*TAG_W +: TAG_W]));
  end
endmodule

bind rs_bank rs_bank_chk #(.N(rs_pkg::NUM_ST), .TAG_W(TAG_W)) u_rs_bank_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .disp_stall (disp_stall),
  .cdb_valid  (cdb_valid),
  .cdb_tag    (cdb_tag),
  .iss_valid  (iss_valid),
  .busy_vec   (busy_vec),
  .alloc_vec  (alloc_vec),
  .t1_flat    (t1_flat),
  .t2_flat    (t2_flat)
);

// File: tb/rs_bank_bench.sv
module rs_bank_bench;
  localparam int TW = 4;
  localparam int DW = 8;
  localparam int OW = 3;
  localparam int N  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic disp_valid = 1'b0;
  logic [2:0] disp_unit = '0;
  logic [OW-1:0] disp_op = '0;
  logic [TW-1:0] disp_tag = '0, disp_t1 = '0, disp_t2 = '0;
  logic [DW-1:0] disp_v1 = '0, disp_v2 = '0;
  logic disp_stall;
  logic cdb_valid = 1'b0;
  logic [TW-1:0] cdb_tag = '0;
  logic [DW-1:0] cdb_value = '0;
  logic [N-1:0] iss_valid;
  logic [N*OW-1:0] iss_op;
  logic [N*TW-1:0] iss_tag;
  logic [N*DW-1:0] iss_v1, iss_v2;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rs_bank u_rs_bank (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_unit(disp_unit), .disp_op(disp_op),
    .disp_tag(disp_tag), .disp_t1(disp_t1), .disp_t2(disp_t2),
    .disp_v1(disp_v1), .disp_v2(disp_v2), .disp_stall(disp_stall),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_tag(iss_tag),
    .iss_v1(iss_v1), .iss_v2(iss_v2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    disp_valid = 1'b0;
    cdb_valid  = 1'b0;
    flush      = 1'b0;
  endtask

  task automatic drive(input int u, input int op, input int tag, input int t1,
                       input int t2, input int v1, input int v2);
    disp_valid = 1'b1;
    disp_unit  = 3'(u);
    disp_op    = OW'(op);
    disp_tag   = TW'(tag);
    disp_t1    = TW'(t1);
    disp_t2    = TW'(t2);
    disp_v1    = DW'(v1);
    disp_v2    = DW'(v2);
  endtask

  task automatic bcast(input int tag, input int val);
    cdb_valid = 1'b1;
    cdb_tag   = TW'(tag);
    cdb_value = DW'(val);
  endtask

  function automatic logic [31:0] lane_op(input int u); return 32'(iss_op[u*OW +: OW]); endfunction
  function automatic logic [31:0] lane_tag(input int u); return 32'(iss_tag[u*TW +: TW]); endfunction
  function automatic logic [31:0] lane_v1(input int u); return 32'(iss_v1[u*DW +: DW]); endfunction
  function automatic logic [31:0] lane_v2(input int u); return 32'(iss_v2[u*DW +: DW]); endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int a_list[4];
    int b_list[4];
    a_list = '{3, 12, 7, 15};
    b_list = '{5, 3, 7, 1};

    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1: empty after reset
    chk("R1 iss_valid", 32'(iss_valid), 0);
    drive(0, 0, 1, 0, 0, 0, 0);
    #1 chk("R1 stall", 32'(disp_stall), 0);
    idle();
    cyc();

    // R2 / R7: ready dispatch sweep over every unit and op code
    for (int u = 0; u < N; u++) begin
      for (int op = 0; op < 8; op++) begin
        int tag, v1, v2;
        tag = ((u * 3 + op) % 15) + 1;
        v1  = (u * 40 + op * 5) % 256;
        v2  = 255 - v1;
        drive(u, op, tag, 0, 0, v1, v2);
        #1 chk("R7 no stall after free", 32'(disp_stall), 0);
        cyc();
        idle();
        chk("R2 iss_valid", 32'(iss_valid), 32'(1 << u));
        chk("R2 op", lane_op(u), 32'(op));
        chk("R2 tag", lane_tag(u), 32'(tag));
        chk("R2 v1", lane_v1(u), 32'(v1));
        chk("R2 v2", lane_v2(u), 32'(v2));
        cyc();
        chk("R7 one cycle", 32'(iss_valid), 0);
      end
    end

    // R5 / R3 / R10: tag sweeps on the ALU station
    for (int p = 0; p < 4; p++) begin
      int a, b, ev1, ev2;
      bit pend1, pend2, busy;
      a = a_list[p];
      b = b_list[p];
      drive(0, 5, 9, a, b, 0, 0);
      cyc();
      idle();
      chk("R4 pending no issue", 32'(iss_valid), 0);
      // R3: refused dispatch to the occupied station
      drive(0, 2, 4, 0, 0, 8'hEE, 8'hDD);
      #1 chk("R3 stall", 32'(disp_stall), 1);
      // R5: matching tag with cdb_valid low does nothing
      cdb_valid = 1'b0;
      cdb_tag = TW'(a);
      cdb_value = 8'h99;
      cyc();
      idle();
      chk("R5 invalid bus ignored", 32'(iss_valid), 0);
      pend1 = 1; pend2 = 1; busy = 1; ev1 = 0; ev2 = 0;
      for (int k = 1; k < 16; k++) begin
        bcast(k, 16 + k);
        if (busy && !pend1 && !pend2) busy = 0;
        else if (busy) begin
          if (pend1 && k == a) begin pend1 = 0; ev1 = 16 + k; end
          if (pend2 && k == b) begin pend2 = 0; ev2 = 16 + k; end
        end
        cyc();
        idle();
        chk("R5 sweep issue", 32'(iss_valid[0]), 32'(busy && !pend1 && !pend2));
        if (busy && !pend1 && !pend2) begin
          chk("R5 v1", lane_v1(0), 32'(ev1));
          chk("R5 v2", lane_v2(0), 32'(ev2));
          chk("R3 op kept", lane_op(0), 5);
          chk("R3 tag kept", lane_tag(0), 9);
        end
      end
      cyc();
    end

    // R10: one broadcast wakes sources in all stations
    for (int u = 0; u < N; u++) begin
      drive(u, u, u + 1, 9, (u % 2 == 1) ? 9 : 0, 0, 8'h11);
      cyc();
      idle();
      chk("R10 waiting", 32'(iss_valid), 0);
    end
    bcast(9, 8'h5A);
    cyc();
    idle();
    chk("R10 all issue", 32'(iss_valid), 32'h1F);
    for (int u = 0; u < N; u++) begin
      chk("R10 v1", lane_v1(u), 32'h5A);
      chk("R10 v2", lane_v2(u), (u % 2 == 1) ? 32'h5A : 32'h11);
    end
    cyc();

    // R6: broadcast in the dispatch cycle is captured
    drive(3, 1, 2, 6, 6, 0, 0);
    bcast(6, 8'h33);
    cyc();
    idle();
    chk("R6 bypass issue", 32'(iss_valid), 32'(1 << 3));
    chk("R6 v1", lane_v1(3), 32'h33);
    chk("R6 v2", lane_v2(3), 32'h33);
    cyc();
    drive(4, 1, 2, 6, 7, 0, 0);
    bcast(6, 8'h44);
    cyc();
    idle();
    chk("R6 partial bypass", 32'(iss_valid), 0);
    bcast(7, 8'h45);
    cyc();
    idle();
    chk("R6 then R5 issue", 32'(iss_valid), 32'(1 << 4));
    chk("R6 v1 kept", lane_v1(4), 32'h44);
    cyc();

    // R8: flush empties bank and beats same-cycle dispatch
    drive(0, 1, 3, 2, 0, 0, 0);
    cyc();
    drive(1, 1, 4, 2, 0, 0, 0);
    cyc();
    drive(2, 1, 5, 0, 0, 1, 1);
    flush = 1'b1;
    cyc();
    idle();
    chk("R8 flush no issue", 32'(iss_valid), 0);
    bcast(2, 8'h77);
    cyc();
    idle();
    chk("R8 stale tag", 32'(iss_valid), 0);
    for (int u = 0; u < 3; u++) begin
      drive(u, 0, 1, 0, 0, 0, 0);
      #1 chk("R8 free after flush", 32'(disp_stall), 0);
      cyc();
      idle();
      cyc();
    end

    // R9: undefined unit codes
    for (int u = 5; u < 8; u++) begin
      drive(u, 0, 1, 0, 0, 0, 0);
      #1 chk("R9 stall", 32'(disp_stall), 1);
      cyc();
      idle();
      chk("R9 nothing allocated", 32'(iss_valid), 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule